// File: doc/BRIEF.md
# Hex Floating-Point Halve Unit

This unit halves a hexadecimal-radix floating-point number. The operand word holds a sign bit, a 7-bit excess-64 characteristic and a fraction of hex digits. A format input selects one of two lengths. In the long format all 14 fraction digits are used. In the short format only the upper 32 bits of the word are used, which gives 6 fraction digits.

The fraction moves right by one bit. The bit that falls off the bottom enters the top of a guard digit. The fraction and guard digit are then normalized together in whole hex-digit steps, and each step lowers the characteristic by one. Finally the guard digit is dropped to truncate the result. Because the guard digit takes part in normalization, a fraction holding only its lowest bit still gives a nonzero result.

When the characteristic drops below zero, a mask input decides the outcome:
- With the mask set, the block wraps the characteristic by 128 and raises an underflow flag.
- With the mask clear, the block returns true zero.

A valid pulse launches one operation. The result is registered and appears one clock later.

Top module: `hfh_halve`

## Requirements
- R1: One clock after a cycle with `inValid` high, `resValid` is high and `resWord`/`resUflow` hold that operation's result; `resValid` is low in every other cycle.
- R2: Result fraction = input fraction shifted right one bit with the dropped bit as the MSB of a 4-bit guard digit, normalized over fraction+guard in hex-digit steps (each step lowers the characteristic, bits [62:56], by one), then truncated. Word layout: sign bit 63, characteristic bits [62:56], fraction bits [55:0].
- R3: A fraction whose only set bit is the lowest fraction bit yields leading digit 8. In long format this is `0x8000...`, with the characteristic lowered by 14. In short format it is `0x800000`, with the characteristic lowered by 6.
- R4: If the final characteristic would be negative and the mask `uflowMask` is 1, the characteristic is delivered plus 128 and `resUflow` is 1. A result characteristic of exactly 0 is not an underflow.
- R5: On underflow with `uflowMask` 0, `resWord` is all zeros and `resUflow` is 0.
- R6: An input fraction of zero gives an all-zero `resWord` and `resUflow` 0, whatever the sign, characteristic or mask.
- R7: The result sign equals the input sign, except that an all-zero result has sign 0.
- R8: With `isLong` 0, input bits [31:0] are ignored and result bits [31:0] are zero.
- R9: During and after reset, before any operation, `resValid`, `resWord` and `resUflow` are zero.
- R10: Every nonzero result has a nonzero leading fraction digit (bits [55:52]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Launch one halve operation |
| isLong | input | 1 | 1 = long format, 0 = short format (upper 32 bits) |
| uflowMask | input | 1 | 1 = wrap characteristic and flag on underflow, 0 = true zero |
| opIn | input | 64 | Operand word |
| resValid | output | 1 | Result valid, one clock after `inValid` |
| resWord | output | 64 | Halved result word |
| resUflow | output | 1 | Exponent-underflow flag for the result |

## Verification
The assertions assume that `inValid` and the operand inputs are steady around the clock edge and that reset is held for at least one edge before the first operation. The bench changes every input only on the falling edge and raises `inValid` for a single cycle at a time. It holds `inValid` low during reset. Short-format operands are given random low halves, so the assumption that those bits are ignored is tested directly rather than relied on.

// File: rtl/hfh_pkg.sv
package hfh_pkg;
  localparam int CHAR_W      = 7;
  localparam int LONG_DIGITS = 14;
  localparam int SHORT_DIGITS = 6;

  typedef struct packed {
    logic capture;
    logic forceZero;
    logic raiseUflow;
  } hfhStrobes_t;
endpackage

// File: rtl/hfh_datapath.sv
module hfh_datapath
  import hfh_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int LD = LONG_DIGITS,
  parameter int SD = SHORT_DIGITS,
  localparam int FRAC_W = 4 * LD,
  localparam int WORD_W = 1 + CW + FRAC_W,
  localparam int EXT_DIGITS = LD + 1,
  localparam int EXT_W = 4 * EXT_DIGITS,
  localparam int LZ_W = $clog2(EXT_DIGITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] opIn,
  input  logic              isLong,
  input  hfhStrobes_t       strobes,
  output logic [LZ_W-1:0]   lzCount,
  output logic              fracZero,
  output logic [CW-1:0]     inChar,
  output logic [WORD_W-1:0] resWord,
  output logic              resUflow
);
  logic [FRAC_W-1:0] fracMask;
  logic [FRAC_W-1:0] fracIn;
  logic [EXT_W-1:0]  extFrac;
  logic [EXT_W-1:0]  shifted;
  logic [EXT_DIGITS-1:0] digitNz;
  logic [FRAC_W-1:0] normFrac;
  logic [CW-1:0]     newChar;
  logic              found;

  // Short format keeps only the top SD digits; lower digits are masked per digit.
  genvar g;
  generate
    for (g = 0; g < LD; g++) begin : gMask
      if (g >= LD - SD) begin : gKeep
        assign fracMask[4*g +: 4] = 4'hF;
      end else begin : gDrop
        assign fracMask[4*g +: 4] = {4{isLong}};
      end
    end
    for (g = 0; g < EXT_DIGITS; g++) begin : gNz
      assign digitNz[g] = |extFrac[4*g +: 4];
    end
  endgenerate

  assign inChar   = opIn[WORD_W-2 -: CW];
  assign fracIn   = opIn[FRAC_W-1:0] & fracMask;
  assign fracZero = (fracIn == '0);
  // One-bit right shift into a fraction extended by a guard digit.
  assign extFrac  = {1'b0, fracIn, 3'b000};

  always_comb begin
    lzCount = '0;
    found   = 1'b0;
    for (int d = EXT_DIGITS - 1; d >= 0; d--) begin
      if (!found) begin
        if (digitNz[d]) found = 1'b1;
        else lzCount = lzCount + LZ_W'(1);
      end
    end
  end

  assign shifted  = extFrac << (4 * lzCount);
  assign normFrac = shifted[EXT_W-1 -: FRAC_W] & fracMask;
  assign newChar  = inChar - CW'(lzCount);

  always_ff @(posedge clk) begin
    if (rst) begin
      resWord  <= '0;
      resUflow <= 1'b0;
    end else if (strobes.capture) begin
      resUflow <= strobes.raiseUflow;
      if (strobes.forceZero) resWord <= '0;
      else resWord <= {opIn[WORD_W-1], newChar, normFrac};
    end
  end
endmodule

// File: rtl/hfh_control.sv
module hfh_control
  import hfh_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int LZ_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic            uflowMask,
  input  logic [LZ_W-1:0] lzCount,
  input  logic            fracZero,
  input  logic [CW-1:0]   inChar,
  output hfhStrobes_t     strobes,
  output logic            resValid
);
  logic underflow;

  // Characteristic would go negative when more digits shift out than it holds.
  assign underflow = (CW+1)'(lzCount) > (CW+1)'(inChar);

  always_comb begin
    strobes.capture    = inValid;
    strobes.forceZero  = fracZero | (underflow & ~uflowMask);
    strobes.raiseUflow = underflow & uflowMask & ~fracZero;
  end

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else resValid <= inValid;
  end
endmodule

// File: rtl/hfh_halve.sv
module hfh_halve
  import hfh_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int LD = LONG_DIGITS,
  parameter int SD = SHORT_DIGITS,
  localparam int WORD_W = 1 + CW + 4 * LD,
  localparam int LZ_W = $clog2(LD + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              isLong,
  input  logic              uflowMask,
  input  logic [WORD_W-1:0] opIn,
  output logic              resValid,
  output logic [WORD_W-1:0] resWord,
  output logic              resUflow
);
  hfhStrobes_t     strobes;
  logic [LZ_W-1:0] lzCount;
  logic            fracZero;
  logic [CW-1:0]   inChar;

  hfh_datapath #(.CW(CW), .LD(LD), .SD(SD)) dp (
    .clk(clk), .rst(rst), .opIn(opIn), .isLong(isLong), .strobes(strobes),
    .lzCount(lzCount), .fracZero(fracZero), .inChar(inChar),
    .resWord(resWord), .resUflow(resUflow)
  );

  hfh_control #(.CW(CW), .LZ_W(LZ_W)) ctl (
    .clk(clk), .rst(rst), .inValid(inValid), .uflowMask(uflowMask),
    .lzCount(lzCount), .fracZero(fracZero), .inChar(inChar),
    .strobes(strobes), .resValid(resValid)
  );
endmodule

// File: rtl/hfh_halve_chk.sv
module hfh_halve_chk #(
  parameter int WORD_W = 64,
  parameter int FRAC_W = 56
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              isLong,
  input logic              uflowMask,
  input logic [WORD_W-1:0] opIn,
  input logic              resValid,
  input logic [WORD_W-1:0] resWord,
  input logic              resUflow
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> resValid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !resValid);
  // R5
  masked_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !uflowMask) |=> !resUflow);
  // R6
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && opIn[FRAC_W-1:0] == '0) |=> (resWord == '0 && !resUflow));
  // R7
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (resWord[FRAC_W-1:0] == '0 || resWord[WORD_W-1] == $past(opIn[WORD_W-1])));
  // R7
  zero_plus_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resWord[FRAC_W-1:0] == '0) |-> resWord == '0);
  // R8
  short_low_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isLong) |=> resWord[31:0] == '0);
  // R10
  normalized_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resWord[FRAC_W-1:0] != '0) |-> resWord[FRAC_W-1 -: 4] != 4'h0);
endmodule

bind hfh_halve hfh_halve_chk #(.WORD_W(WORD_W), .FRAC_W(4 * LD)) chk (
  .clk(clk), .rst(rst), .inValid(inValid), .isLong(isLong), .uflowMask(uflowMask),
  .opIn(opIn), .resValid(resValid), .resWord(resWord), .resUflow(resUflow)
);

// File: tb/hfh_halve_test.sv
module hfh_halve_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {isLong, mask, opIn, expWord, expFlag}
  localparam logic [130:0] VECS [NVEC] = '{
    {1'b1, 1'b1, 64'h4110000000000000, 64'h4080000000000000, 1'b0}, // R2 one digit
    {1'b1, 1'b0, 64'hC230000000000001, 64'hC218000000000000, 1'b0}, // R2 guard dropped, R7
    {1'b1, 1'b1, 64'h4000000000000001, 64'h3280000000000000, 1'b0}, // R3 long
    {1'b0, 1'b1, 64'h46000001DEADBEEF, 64'h4080000000000000, 1'b0}, // R3 short, R8
    {1'b1, 1'b1, 64'h0010000000000000, 64'h7F80000000000000, 1'b1}, // R4
    {1'b1, 1'b0, 64'h8010000000000000, 64'h0000000000000000, 1'b0}, // R5, R7
    {1'b1, 1'b1, 64'hC500000000000000, 64'h0000000000000000, 1'b0}, // R6
    {1'b0, 1'b1, 64'h8300001000000000, 64'hFE80000000000000, 1'b1}, // R4 short, R8
    {1'b1, 1'b0, 64'h41FFFFFFFFFFFFFF, 64'h417FFFFFFFFFFFFF, 1'b0}, // R2 no shift
    {1'b1, 1'b0, 64'h0020000000000000, 64'h0010000000000000, 1'b0}, // R4 char 0 no underflow
    {1'b0, 1'b1, 64'h4500000012345678, 64'h0000000000000000, 1'b0}, // R6, R8
    {1'b1, 1'b0, 64'h0110000000000000, 64'h0080000000000000, 1'b0}  // R4 boundary
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, isLong = 1'b1, uflowMask = 1'b0;
  logic [63:0] opIn = '0;
  logic resValid, resUflow;
  logic [63:0] resWord;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hfh_halve uut (
    .clk(clk), .rst(rst), .inValid(inValid), .isLong(isLong), .uflowMask(uflowMask),
    .opIn(opIn), .resValid(resValid), .resWord(resWord), .resUflow(resUflow)
  );

  // Reference: halving equals dividing by a normalized two (char 65, fraction 0x2...)
  function automatic void refHalve(input logic lng, input logic msk, input logic [63:0] w,
                                   output logic [63:0] r, output logic f);
    logic [55:0] keep = lng ? {56{1'b1}} : {{24{1'b1}}, 32'h0};
    logic [59:0] e = {w[55:0] & keep, 4'h0} >> 1;
    int c = int'(w[62:56]);
    r = '0; f = 1'b0;
    if (e != '0) begin
      while (e[59:56] == 4'h0) begin e = e << 4; c = c - 1; end
      if (c >= 0) r = {w[63], 7'(c), e[59:4] & keep};
      else if (msk) begin r = {w[63], 7'(c + 128), e[59:4] & keep}; f = 1'b1; end
    end
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got word=%h flag=%b, expected word=%h flag=%b",
               req, act[64:1], act[0], exp[64:1], exp[0]);
    end
  endtask

  task automatic apply(input logic lng, input logic msk, input logic [63:0] w);
    @(negedge clk);
    isLong = lng; uflowMask = msk; opIn = w; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    logic [63:0] ew;
    logic ef;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {resWord, resUflow}, 65'h0);
    check("R9 valid", {64'h0, resValid}, 65'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle", {resWord, resValid}, 65'h0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][130], VECS[i][129], VECS[i][128:65]);
      check($sformatf("R2 table %0d", i), {resWord, resUflow}, VECS[i][64:0]);
      check("R1 valid", {64'h0, resValid}, 65'h1);
    end

    // R1: valid drops the cycle after, result holds
    @(negedge clk);
    check("R1 idle", {64'h0, resValid}, 65'h0);

    // R8: short low half ignored; R3 minimal short fraction with random low bits
    for (int i = 0; i < 20; i++) begin
      apply(1'b0, 1'b1, {8'h40, 24'h000001, 32'($urandom)});
      check("R3 R8 short low ignored", {resWord, resUflow}, {64'h3A80000000000000, 1'b0});
    end

    // R10 / R2 random sweep against reference, varied leading-zero depth
    for (int i = 0; i < 400; i++) begin
      logic [63:0] w = {$urandom, $urandom};
      logic lng = 1'($urandom);
      logic msk = 1'($urandom);
      w[55:0] = w[55:0] >> (4 * ($urandom % 15));
      w[62:56] = 7'($urandom % 20);
      refHalve(lng, msk, w, ew, ef);
      apply(lng, msk, w);
      check("R2 R4 R5 R10 random", {resWord, resUflow}, {ew, ef});
    end

    // R9 reset mid-run clears outputs
    apply(1'b1, 1'b1, 64'h0010000000000000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset again", {resWord, resUflow}, 65'h0);
    finishRun();
  end
endmodule